// File: doc/BRIEF.md
# Packed Dual 16-bit Integer ALU

The block treats every 32-bit operand as two independent 16-bit lanes and applies one integer operation to both lanes in the same cycle. An operation is issued by raising `in_valid` together with an opcode, up to three sources and a set of per-source half-select bits. The result word and a valid flag come out of registers exactly one cycle later, so an operation can be issued every cycle.

Each result lane can draw its operands from either half of every source. This lets one operation swap, broadcast or mix halves without a separate permute step. The operation set covers multiply-add, low-half multiply, signed and unsigned add and subtract, three shifts, and signed and unsigned minimum and maximum. A clamp input turns the four add and subtract forms into saturating ones. Opcodes with no operation assigned return zero and raise an illegal flag.

Top module: `pk16_alu`

## Requirements
- R1: While `rst_n` is low, and on the first edge after it, `out_valid`, `out_illegal` and `out_result` are all zero.
- R2: `out_valid` is high in exactly the cycles that follow a cycle with `in_valid` high, and `out_result` then holds the result of that issued operation.
- R3: With clamp off, opcodes 0x02 (signed add), 0x03 (signed subtract), 0x0a (unsigned add) and 0x0b (unsigned subtract) compute a+b or a-b modulo 2^16 in each lane, with no carry or borrow passing between lanes.
- R4: With clamp on, opcode 0x02 and opcode 0x03 saturate each lane to the range -32768..32767 instead of wrapping.
- R5: With clamp on, opcode 0x0a saturates each lane at 0xFFFF and opcode 0x0b saturates each lane at 0x0000.
- R6: Opcode 0x01 returns the low 16 bits of a*b per lane; opcodes 0x00 (signed) and 0x09 (unsigned) return a*b+c modulo 2^16 per lane. Clamp has no effect on these.
- R7: Opcode 0x04 shifts left, 0x05 shifts right filling zeros, and 0x06 shifts right copying the sign bit. The value shifted comes from source b. The amount is the low 4 bits of the matching lane of source a.
- R8: Opcodes 0x07 and 0x08 return the signed maximum and minimum of a and b per lane. Opcodes 0x0c and 0x0d return the unsigned maximum and minimum.
- R9: Bit k of `sel_lo` picks the half of source k (0=a, 1=b, 2=c) that feeds the low result lane, and bit k of `sel_hi` does the same for the high result lane. A value of 0 picks bits 15:0 and a value of 1 picks bits 31:16.
- R10: Opcodes 0x0e through 0x1f give a zero `out_result`, and `out_illegal` is high together with `out_valid`. For assigned opcodes `out_illegal` stays low.
- R11: In a cycle where `in_valid` is low, `out_result` keeps its previous value and the other inputs have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Issue strobe |
| opcode | input | 5 | Operation code |
| src_a | input | 32 | Source a (shift amount for shifts) |
| src_b | input | 32 | Source b (shifted value for shifts) |
| src_c | input | 32 | Source c (addend for multiply-add) |
| sel_lo | input | 3 | Per-source half select for the low result lane |
| sel_hi | input | 3 | Per-source half select for the high result lane |
| clamp_en | input | 1 | Saturate add and subtract |
| out_valid | output | 1 | Result valid, one cycle after issue |
| out_result | output | 32 | Packed two-lane result |
| out_illegal | output | 1 | Issued opcode was unassigned |

## Verification
The assertions assume that the opcode, sources, select bits and clamp input carry known values in every cycle where `in_valid` is high. They also assume that reset is held for at least one clock edge before the first issue. The bench drives every input from tasks on the falling edge. It sets all of them to defined values before it first raises `in_valid`, and it keeps them defined between issues, so the idle-cycle hold check sees deliberately changed but still defined inputs.

// File: rtl/pk16_alu.sv
module pk16_alu #(
  parameter int LANE_W = 16,
  parameter int OPC_W  = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic [OPC_W-1:0]      opcode,
  input  logic [2*LANE_W-1:0]   src_a,
  input  logic [2*LANE_W-1:0]   src_b,
  input  logic [2*LANE_W-1:0]   src_c,
  input  logic [2:0]            sel_lo,
  input  logic [2:0]            sel_hi,
  input  logic                  clamp_en,
  output logic                  out_valid,
  output logic [2*LANE_W-1:0]   out_result,
  output logic                  out_illegal
);
  localparam int DW  = 2 * LANE_W;
  localparam int SHW = $clog2(LANE_W);

  localparam logic [OPC_W-1:0] OP_MAD_S = 5'h00, OP_MUL_LO = 5'h01, OP_ADD_S = 5'h02,
                               OP_SUB_S = 5'h03, OP_SHL    = 5'h04, OP_SHR_L = 5'h05,
                               OP_SHR_A = 5'h06, OP_MAX_S  = 5'h07, OP_MIN_S = 5'h08,
                               OP_MAD_U = 5'h09, OP_ADD_U  = 5'h0a, OP_SUB_U = 5'h0b,
                               OP_MAX_U = 5'h0c, OP_MIN_U  = 5'h0d;

  localparam logic [LANE_W-1:0] S_MAX = {1'b0, {(LANE_W-1){1'b1}}};
  localparam logic [LANE_W-1:0] S_MIN = {1'b1, {(LANE_W-1){1'b0}}};

  function automatic logic [LANE_W-1:0] lane_calc(
    input logic [OPC_W-1:0]  op,
    input logic              clp,
    input logic [LANE_W-1:0] a,
    input logic [LANE_W-1:0] b,
    input logic [LANE_W-1:0] c
  );
    logic [LANE_W:0]     sum_s, dif_s, sum_u, dif_u;
    logic [2*LANE_W-1:0] prod;
    logic [SHW-1:0]      amt;
    logic                lt_s, lt_u;
    sum_s = {a[LANE_W-1], a} + {b[LANE_W-1], b};
    dif_s = {a[LANE_W-1], a} - {b[LANE_W-1], b};
    sum_u = {1'b0, a} + {1'b0, b};
    dif_u = {1'b0, a} - {1'b0, b};
    prod  = {{LANE_W{1'b0}}, a} * {{LANE_W{1'b0}}, b};
    amt   = a[SHW-1:0];
    lt_s  = $signed(a) < $signed(b);
    lt_u  = a < b;
    case (op)
      OP_MAD_S, OP_MAD_U: lane_calc = prod[LANE_W-1:0] + c;
      OP_MUL_LO:          lane_calc = prod[LANE_W-1:0];
      OP_ADD_S: lane_calc = (clp && (sum_s[LANE_W] != sum_s[LANE_W-1]))
                            ? (sum_s[LANE_W] ? S_MIN : S_MAX) : sum_s[LANE_W-1:0];
      OP_SUB_S: lane_calc = (clp && (dif_s[LANE_W] != dif_s[LANE_W-1]))
                            ? (dif_s[LANE_W] ? S_MIN : S_MAX) : dif_s[LANE_W-1:0];
      OP_ADD_U: lane_calc = (clp && sum_u[LANE_W]) ? {LANE_W{1'b1}} : sum_u[LANE_W-1:0];
      OP_SUB_U: lane_calc = (clp && dif_u[LANE_W]) ? {LANE_W{1'b0}} : dif_u[LANE_W-1:0];
      OP_SHL:   lane_calc = b << amt;
      OP_SHR_L: lane_calc = b >> amt;
      OP_SHR_A: lane_calc = $unsigned($signed(b) >>> amt);
      OP_MAX_S: lane_calc = lt_s ? b : a;
      OP_MIN_S: lane_calc = lt_s ? a : b;
      OP_MAX_U: lane_calc = lt_u ? b : a;
      OP_MIN_U: lane_calc = lt_u ? a : b;
      default:  lane_calc = '0;
    endcase
  endfunction

  logic [DW-1:0] lane_word;
  logic          illegal;

  assign illegal = (opcode > OP_MIN_U);

  for (genvar l = 0; l < 2; l++) begin : g_lane
    logic [2:0]        hsel;
    logic [LANE_W-1:0] la, lb, lc;
    assign hsel = (l == 0) ? sel_lo : sel_hi;
    assign la = hsel[0] ? src_a[DW-1:LANE_W] : src_a[LANE_W-1:0];
    assign lb = hsel[1] ? src_b[DW-1:LANE_W] : src_b[LANE_W-1:0];
    assign lc = hsel[2] ? src_c[DW-1:LANE_W] : src_c[LANE_W-1:0];
    assign lane_word[l*LANE_W +: LANE_W] = lane_calc(opcode, clamp_en, la, lb, lc);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_illegal <= 1'b0;
      out_result  <= '0;
    end else begin
      out_valid   <= in_valid;
      out_illegal <= in_valid && illegal;
      if (in_valid) out_result <= illegal ? '0 : lane_word;
    end
  end

  assert_issue_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_idle_novalid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_result));
  assert_illegal_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_illegal |-> (out_valid && out_result == '0));
  assert_illegal_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode > OP_MIN_U) |=> out_illegal);
  assert_legal_noflag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode <= OP_MIN_U) |=> !out_illegal);
endmodule

// File: tb/test_pk16_alu.sv
module test_pk16_alu;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        in_valid = 0;
  logic [4:0]  opcode = '0;
  logic [31:0] src_a = '0, src_b = '0, src_c = '0;
  logic [2:0]  sel_lo = 3'b000, sel_hi = 3'b111;
  logic        clamp_en = 0;
  logic        out_valid, out_illegal;
  logic [31:0] out_result;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  pk16_alu i_pk16_alu (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
    .src_a(src_a), .src_b(src_b), .src_c(src_c), .sel_lo(sel_lo), .sel_hi(sel_hi),
    .clamp_en(clamp_en), .out_valid(out_valid), .out_result(out_result),
    .out_illegal(out_illegal)
  );

  function automatic longint sx(input longint v);
    return (v >= 32768) ? v - 65536 : v;
  endfunction

  function automatic logic [15:0] ref_lane(input int op, input bit clp,
                                           input longint a, input longint b, input longint c);
    longint r, sa, sb;
    int sh;
    sa = sx(a); sb = sx(b); sh = int'(a % 16);
    case (op)
      0, 9: r = a * b + c;
      1:    r = a * b;
      2, 3: begin
        r = (op == 2) ? sa + sb : sa - sb;
        if (clp && r > 32767) r = 32767;
        if (clp && r < -32768) r = -32768;
      end
      10: begin r = a + b; if (clp && r > 65535) r = 65535; end
      11: begin r = a - b; if (clp && r < 0) r = 0; end
      4: r = b * (longint'(1) << sh);
      5: r = b / (longint'(1) << sh);
      6: r = (sb >= 0) ? sb / (longint'(1) << sh) : -((-sb + (longint'(1) << sh) - 1) / (longint'(1) << sh));
      7: r = (sa > sb) ? sa : sb;
      8: r = (sa < sb) ? sa : sb;
      12: r = (a > b) ? a : b;
      13: r = (a < b) ? a : b;
      default: r = 0;
    endcase
    r = r % 65536;
    if (r < 0) r = r + 65536;
    return r[15:0];
  endfunction

  function automatic string tag(input int op, input bit clp);
    case (op)
      0, 1, 9:       return "R6";
      2, 3:          return clp ? "R4" : "R3";
      10, 11:        return clp ? "R5" : "R3";
      4, 5, 6:       return "R7";
      7, 8, 12, 13:  return "R8";
      default:       return "R10";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] pick(input logic [31:0] s, input bit hi);
    return hi ? s[31:16] : s[15:0];
  endfunction

  task automatic issue_and_check(input int op, input bit clp, input logic [31:0] a,
                                 input logic [31:0] b, input logic [31:0] c,
                                 input logic [2:0] sl, input logic [2:0] sh, input string req);
    logic [15:0] e0, e1;
    @(negedge clk);
    opcode = op[4:0]; clamp_en = clp; src_a = a; src_b = b; src_c = c;
    sel_lo = sl; sel_hi = sh; in_valid = 1;
    e0 = ref_lane(op, clp, pick(a, sl[0]), pick(b, sl[1]), pick(c, sl[2]));
    e1 = ref_lane(op, clp, pick(a, sh[0]), pick(b, sh[1]), pick(c, sh[2]));
    @(negedge clk);
    in_valid = 0;
    check({req, " R2 valid"}, {31'b0, out_valid}, 32'd1);
    check(req, out_result, {e1, e0});
    check({req, " illegal flag"}, {31'b0, out_illegal}, {31'b0, (op > 13)});
  endtask

  initial begin
    logic [15:0] vals [8];
    vals = '{16'h0000, 16'h0001, 16'h0007, 16'h7fff, 16'h8000, 16'h8001, 16'hfffe, 16'hffff};
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 valid", {31'b0, out_valid}, 0);
    check("R1 illegal", {31'b0, out_illegal}, 0);
    check("R1 result", out_result, 0);
    rst_n = 1;
    // sweep all opcodes, clamp settings, corner lane values
    for (int op = 0; op < 32; op++)
      for (int cl = 0; cl < 2; cl++)
        for (int i = 0; i < 8; i++)
          for (int j = 0; j < 8; j++)
            issue_and_check(op, cl[0], {vals[7-i], vals[i]}, {vals[(j+3)%8], vals[j]},
                            {vals[(i+j)%8], 16'h1234}, 3'b000, 3'b111, tag(op, cl[0]));
    // R9: every half-select combination with distinct halves
    for (int sl = 0; sl < 8; sl++)
      for (int sh = 0; sh < 8; sh++)
        issue_and_check(0, 0, 32'h0003_0010, 32'h0020_0005, 32'h0700_0009,
                        sl[2:0], sh[2:0], "R9");
    // R11: idle cycles with changed inputs keep the result
    issue_and_check(10, 0, 32'h0001_0002, 32'h0003_0004, 32'h0, 3'b000, 3'b111, "R3");
    @(negedge clk);
    opcode = 5'h01; src_a = 32'hffff_ffff; src_b = 32'h1234_5678; clamp_en = 1;
    repeat (3) @(negedge clk);
    check("R11 hold", out_result, 32'h0004_0006);
    check("R11 no valid", {31'b0, out_valid}, 0);
    // R1: reset clears after activity
    rst_n = 0;
    @(negedge clk);
    check("R1 result after reset", out_result, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1_500_000;
    total++; bad++;
    $display("FAIL watchdog R2 actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule